// File: doc/BRIEF.md
# Display Controller Command Sequencer

This block steps a byte transmitter through the fixed command scripts that a small graphic display controller needs outside of pixel traffic. There are four scripts: a staged power-up, sleep entry, sleep exit and a contrast change. Each script starts from a one-cycle pulse on its own input. The block keeps `busy` high until the script has ended and the chip select has been let go.

Every byte is presented on a valid/ready pair. The command/data select line stays in command mode and chip select stays low for the whole script, including the timed pauses. The scripts live in a small internal table of entries: opcode bytes, pause lengths in milliseconds, a slot for the contrast argument, and an end marker. A millisecond is a parameterised number of clock cycles (`MS_CYCLES`), so a reduced value can stand in for real time.

Top module: `lcd_cmd_seq`

## Requirements
- R1: After reset `busy` is 0, `csN` is 1 and `txValid` is 0.
- R2: A power-up script sends exactly these bytes in order: A2, A0, C8, 40, 2C, 2E, 2F, 10, A6, 81, 1E, AF, A5, A4 (hex).
- R3: Each pause lasts `ms*MS_CYCLES` cycles in the wait state. With `txReady` held, the next byte follows the byte before the pause after `ms*MS_CYCLES+1` cycles without `txValid`. Back-to-back bytes have no such gap. In power-up the pauses are 50 ms after each of 2C, 2E and 2F, 100 ms after AF, and 200 ms after A5.
- R4: Sleep entry sends AC, AE, A5, and releases chip select one cycle after the last byte is taken.
- R5: Sleep exit sends A4, then AF. It then holds `busy` for a 50 ms pause, so `busy` stays high for `50*MS_CYCLES+2` cycles after AF is accepted.
- R6: A contrast change sends 81 and then the `contrastIn` value sampled at the start pulse, shifted right by two bits.
- R7: While `txValid` is 1 and `txReady` is 0, `txValid` and `txByte` hold on the next cycle.
- R8: `csN` is 0 in every cycle that `busy` is 1, including pauses, and 1 when idle. `dataMode` is always 0 (command mode).
- R9: A start pulse on any input while `busy` is 1 is ignored. The running script's bytes and timing are unchanged.
- R10: When several start pulses coincide, power-up wins over sleep entry, sleep entry over sleep exit, and sleep exit over contrast.
- R11: `busy` rises in the cycle after an accepted start pulse and never rises without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startInit | input | 1 | Pulse: run power-up script |
| startSleep | input | 1 | Pulse: run sleep entry script |
| startWake | input | 1 | Pulse: run sleep exit script |
| startContrast | input | 1 | Pulse: run contrast script |
| contrastIn | input | 8 | Contrast setting, sampled with the start pulse |
| txReady | input | 1 | Transmitter accepts the byte this cycle |
| txValid | output | 1 | Byte on `txByte` is offered |
| txByte | output | 8 | Command byte |
| csN | output | 1 | Display chip select, active low |
| dataMode | output | 1 | Command/data select, held 0 (command) |
| busy | output | 1 | A script is running |

## Verification
The assertions assume that the start inputs are single-cycle pulses and that the transmitter may withhold `txReady` for any number of cycles without ever forcing a byte. The bench drives every start for exactly one cycle, always well clear of reset. It runs each script both with `txReady` held high and with `txReady` following a pseudo-random pattern. It sweeps all 256 contrast values, and it fires competing and overlapping pulses to exercise priority and the ignore rule.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {K_OP, K_WAIT, K_ARG, K_END} kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [7:0] val;
  } entry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchArg;
    logic loadWait;
    logic waitRun;
    logic selArg;
  } strobe_t;

  localparam int PC_W = 5;
  localparam logic [PC_W-1:0] BASE_INIT  = 5'd0;
  localparam logic [PC_W-1:0] BASE_SLEEP = 5'd20;
  localparam logic [PC_W-1:0] BASE_WAKE  = 5'd24;
  localparam logic [PC_W-1:0] BASE_TRIM  = 5'd28;

  localparam logic [7:0] OP_TRIM  = 8'h81;
  localparam logic [7:0] OP_NAP   = 8'hAC;

  function automatic logic [7:0] opBias(input logic f);      return 8'hA2 | {7'd0, f}; endfunction
  function automatic logic [7:0] opColDir(input logic f);    return 8'hA0 | {7'd0, f}; endfunction
  function automatic logic [7:0] opComScan(input logic f);   return 8'hC0 | {4'd0, f, 3'd0}; endfunction
  function automatic logic [7:0] opFirstRow(input logic [5:0] r); return 8'h40 | {2'd0, r}; endfunction
  function automatic logic [7:0] opSupply(input logic [2:0] s);   return 8'h28 | {5'd0, s}; endfunction
  function automatic logic [7:0] opRatio(input logic [2:0] r);    return 8'h10 | {5'd0, r}; endfunction
  function automatic logic [7:0] opInvert(input logic f);    return 8'hA6 | {7'd0, f}; endfunction
  function automatic logic [7:0] opPanel(input logic f);     return 8'hAE | {7'd0, f}; endfunction
  function automatic logic [7:0] opFlood(input logic f);     return 8'hA4 | {7'd0, f}; endfunction

  function automatic entry_t eOp(input logic [7:0] b);   return '{kind: K_OP,   val: b};    endfunction
  function automatic entry_t eWait(input logic [7:0] m); return '{kind: K_WAIT, val: m};    endfunction

  function automatic entry_t romEntry(input logic [PC_W-1:0] idx);
    case (idx)
      5'd0:  return eOp(opBias(1'b0));
      5'd1:  return eOp(opColDir(1'b0));
      5'd2:  return eOp(opComScan(1'b1));
      5'd3:  return eOp(opFirstRow(6'd0));
      5'd4:  return eOp(opSupply(3'd4));
      5'd5:  return eWait(8'd50);
      5'd6:  return eOp(opSupply(3'd6));
      5'd7:  return eWait(8'd50);
      5'd8:  return eOp(opSupply(3'd7));
      5'd9:  return eWait(8'd50);
      5'd10: return eOp(opRatio(3'd0));
      5'd11: return eOp(opInvert(1'b0));
      5'd12: return eOp(OP_TRIM);
      5'd13: return eOp(8'h1E);
      5'd14: return eOp(opPanel(1'b1));
      5'd15: return eWait(8'd100);
      5'd16: return eOp(opFlood(1'b1));
      5'd17: return eWait(8'd200);
      5'd18: return eOp(opFlood(1'b0));
      5'd20: return eOp(OP_NAP);
      5'd21: return eOp(opPanel(1'b0));
      5'd22: return eOp(opFlood(1'b1));
      5'd24: return eOp(opFlood(1'b0));
      5'd25: return eOp(opPanel(1'b1));
      5'd26: return eWait(8'd50);
      5'd28: return eOp(OP_TRIM);
      5'd29: return '{kind: K_ARG, val: 8'h00};
      default: return '{kind: K_END, val: 8'h00};
    endcase
  endfunction

endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startInit,
  input  logic       startSleep,
  input  logic       startWake,
  input  logic       startContrast,
  input  logic       txReady,
  input  logic       waitDone,
  output strobe_t    strb,
  output logic [7:0] entryVal,
  output logic       txValid,
  output logic       busy
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} state_e;

  state_e          state, stateNext;
  logic [PC_W-1:0] pc, pcNext;
  entry_t          cur;
  logic            startAny;
  logic [PC_W-1:0] startBase;

  assign startAny = startInit | startSleep | startWake | startContrast;

  always_comb begin
    if (startInit)       startBase = BASE_INIT;
    else if (startSleep) startBase = BASE_SLEEP;
    else if (startWake)  startBase = BASE_WAKE;
    else                 startBase = BASE_TRIM;
  end

  always_comb cur = romEntry(pc);
  assign entryVal = cur.val;

  always_comb begin
    stateNext = state;
    pcNext    = pc;
    strb      = '0;
    txValid   = 1'b0;
    case (state)
      S_IDLE: begin
        if (startAny) begin
          stateNext     = S_RUN;
          pcNext        = startBase;
          strb.latchArg = 1'b1;
        end
      end
      S_RUN: begin
        case (cur.kind)
          K_OP, K_ARG: begin
            txValid     = 1'b1;
            strb.selArg = (cur.kind == K_ARG);
            if (txReady) pcNext = pc + 1'b1;
          end
          K_WAIT: begin
            strb.loadWait = 1'b1;
            stateNext     = S_WAIT;
          end
          default: stateNext = S_IDLE;
        endcase
      end
      S_WAIT: begin
        strb.waitRun = 1'b1;
        if (waitDone) begin
          pcNext    = pc + 1'b1;
          stateNext = S_RUN;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      pc    <= '0;
    end else begin
      state <= stateNext;
      pc    <= pcNext;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/lcd_seq_datapath.sv
module lcd_seq_datapath
  import lcd_seq_pkg::*;
#(
  parameter int MS_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [7:0] entryVal,
  input  logic [7:0] contrastIn,
  output logic       waitDone,
  output logic [7:0] txByte
);

  localparam int PW = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(MS_CYCLES - 1);

  logic [PW-1:0] preCnt;
  logic [7:0]    msLeft;
  logic [7:0]    argReg;
  logic          msTick;

  assign msTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      msLeft <= '0;
      argReg <= '0;
    end else begin
      if (strb.latchArg) argReg <= contrastIn;
      if (strb.loadWait) begin
        msLeft <= entryVal;
        preCnt <= '0;
      end else if (strb.waitRun) begin
        if (msTick) begin
          preCnt <= '0;
          msLeft <= msLeft - 8'd1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  assign waitDone = strb.waitRun && msTick && (msLeft == 8'd1);
  assign txByte   = strb.selArg ? {2'b00, argReg[7:2]} : entryVal;

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter int MS_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startInit,
  input  logic       startSleep,
  input  logic       startWake,
  input  logic       startContrast,
  input  logic [7:0] contrastIn,
  input  logic       txReady,
  output logic       txValid,
  output logic [7:0] txByte,
  output logic       csN,
  output logic       dataMode,
  output logic       busy
);

  strobe_t    strb;
  logic [7:0] entryVal;
  logic       waitDone;

  lcd_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startInit(startInit), .startSleep(startSleep),
    .startWake(startWake), .startContrast(startContrast),
    .txReady(txReady), .waitDone(waitDone),
    .strb(strb), .entryVal(entryVal),
    .txValid(txValid), .busy(busy)
  );

  lcd_seq_datapath #(.MS_CYCLES(MS_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .entryVal(entryVal),
    .contrastIn(contrastIn), .waitDone(waitDone), .txByte(txByte)
  );

  assign csN      = ~busy;
  assign dataMode = 1'b0;

endmodule

// File: rtl/lcd_cmd_seq_chk.sv
module lcd_cmd_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startInit,
  input logic       startSleep,
  input logic       startWake,
  input logic       startContrast,
  input logic       txReady,
  input logic       txValid,
  input logic [7:0] txByte,
  input logic       csN,
  input logic       busy
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte));

  p_cs_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !csN);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txValid && csN);

  p_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startInit || startSleep || startWake || startContrast));

endmodule

bind lcd_cmd_seq lcd_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startInit(startInit), .startSleep(startSleep),
  .startWake(startWake), .startContrast(startContrast), .txReady(txReady),
  .txValid(txValid), .txByte(txByte), .csN(csN), .busy(busy)
);

// File: tb/lcd_cmd_seq_bench.sv
`timescale 1ns/1ps
module lcd_cmd_seq_bench;

  localparam int P = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startInit = 1'b0, startSleep = 1'b0, startWake = 1'b0, startContrast = 1'b0;
  logic [7:0] contrastIn = 8'h00;
  logic txReady = 1'b1;
  logic txValid, csN, dataMode, busy;
  logic [7:0] txByte;

  always #2.5 clk = ~clk;

  lcd_cmd_seq #(.MS_CYCLES(P)) u_lcd_cmd_seq (
    .clk(clk), .rstN(rstN), .startInit(startInit), .startSleep(startSleep),
    .startWake(startWake), .startContrast(startContrast), .contrastIn(contrastIn),
    .txReady(txReady), .txValid(txValid), .txByte(txByte), .csN(csN),
    .dataMode(dataMode), .busy(busy)
  );

  int checks = 0, errors = 0;
  int gotB[32], gotG[32], nGot = 0, gapCnt = 0, tail = 0;
  int expB[32], expG[32], nExp = 0, expTail = 0;
  bit prevBusy = 0, opDone = 0, stallMode = 0;
  int pinErr = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txReady = stallMode ? lfsr[0] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (dataMode !== 1'b0 || csN !== ~busy) pinErr++;
      if (busy) begin
        if (txValid && txReady) begin
          if (nGot < 32) begin gotB[nGot] = txByte; gotG[nGot] = gapCnt; end
          nGot++;
          gapCnt = 0;
        end else if (!txValid) gapCnt++;
      end else if (prevBusy) begin
        tail = gapCnt; opDone = 1;
      end else gapCnt = 0;
      prevBusy = busy;
    end
  end

  task automatic addB(input int b, input int g);
    expB[nExp] = b; expG[nExp] = g; nExp++;
  endtask

  task automatic setInit();
    nExp = 0;
    addB('hA2,0); addB('hA0,0); addB('hC8,0); addB('h40,0); addB('h2C,0);
    addB('h2E,50*P+1); addB('h2F,50*P+1); addB('h10,50*P+1); addB('hA6,0);
    addB('h81,0); addB('h1E,0); addB('hAF,0); addB('hA5,100*P+1); addB('hA4,200*P+1);
    expTail = 1;
  endtask
  task automatic setSleep();
    nExp = 0; addB('hAC,0); addB('hAE,0); addB('hA5,0); expTail = 1;
  endtask
  task automatic setWake();
    nExp = 0; addB('hA4,0); addB('hAF,0); expTail = 50*P+2;
  endtask
  task automatic setTrim(input int c);
    nExp = 0; addB('h81,0); addB(c >> 2,0); expTail = 1;
  endtask

  // pulse the given starts (bit3 init, 2 sleep, 1 wake, 0 contrast)
  task automatic pulse(input logic [3:0] s, input bit fromIdle);
    @(posedge clk); #1;
    if (fromIdle) begin opDone = 0; nGot = 0; end
    {startInit, startSleep, startWake, startContrast} = s;
    @(negedge clk);
    if (fromIdle) chk(busy == 1'b0, "R11 busy before edge", busy, 0);
    @(posedge clk); #1;
    {startInit, startSleep, startWake, startContrast} = 4'b0;
    @(negedge clk);
    if (fromIdle) chk(busy == 1'b1, "R11 busy after start", busy, 1);
  endtask

  task automatic finishOp(input string req);
    wait (opDone);
    chk(nGot == nExp, {req, " count"}, nGot, nExp);
    for (int i = 0; i < nExp && i < nGot; i++) begin
      chk(gotB[i] == expB[i], {req, " byte"}, gotB[i], expB[i]);
      chk(gotG[i] == expG[i], {req, " R3 gap"}, gotG[i], expG[i]);
    end
    chk(tail == expTail, {req, " tail"}, tail, expTail);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && csN == 1 && txValid == 0, "R1 reset", {busy, csN, txValid}, 3'b010);

    for (int m = 0; m < 2; m++) begin
      stallMode = (m == 1);
      setInit();  pulse(4'b1000, 1); finishOp("R2 init");
      setSleep(); pulse(4'b0100, 1); finishOp("R4 sleep");
      setWake();  pulse(4'b0010, 1); finishOp("R5 wake");
    end

    // R6: all contrast values, alternating stall patterns
    for (int c = 0; c < 256; c++) begin
      stallMode  = c[0];
      contrastIn = 8'(c);
      setTrim(c); pulse(4'b0001, 1);
      contrastIn = 8'(255 - c);
      finishOp("R6 contrast");
    end

    // R10 priority
    stallMode = 0;
    setInit();  pulse(4'b1111, 1); finishOp("R10 init wins");
    setSleep(); pulse(4'b0111, 1); finishOp("R10 sleep wins");
    setWake();  pulse(4'b0011, 1); finishOp("R10 wake wins");

    // R9 starts while busy ignored (during bytes and during a pause)
    setInit(); pulse(4'b1000, 1);
    repeat (2) @(posedge clk);
    pulse(4'b0101, 0);
    repeat (60) @(posedge clk);
    pulse(4'b1010, 0);
    finishOp("R9 ignore init");
    setWake(); pulse(4'b0010, 1);
    repeat (20) @(posedge clk);
    pulse(4'b1101, 0);
    finishOp("R9 ignore wake");

    repeat (3) @(negedge clk);
    chk(pinErr == 0, "R8 cs/dataMode", pinErr, 0);
    chk(busy == 0 && csN == 1, "R8 idle cs", {busy, csN}, 2'b01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule